// File: doc/BRIEF.md
# Threshold Priority Arbiter With Claim Mask

This block performs the arbitration step for a single interrupt target of an interrupt controller. Each cycle it receives one pending bit, one claimed bit and one enable bit per interrupt source, a 3-bit priority per source, and the target's 3-bit threshold. It reports whether the target should be interrupted, which source would be handed out by a claim, and that source's priority.

A source competes only when it is pending, enabled and not already claimed, and only when its priority is strictly greater than the threshold. Among the competitors the highest priority wins. When several share that priority the smallest source number wins. Source number 0 is reserved to mean "nothing to serve" and never competes. The selection logic is a balanced tree of compare-select nodes, so its depth grows with the logarithm of the source count. An optional register stage, chosen by parameter, retimes all three results by one clock.

Top module: `prio_thresh_arb`

## Requirements
- R1: A source counts as a candidate only while its bit in `pend_i` is 1, its bit in `en_i` is 1 and its bit in `clm_i` is 0. Bit i of each vector belongs to source i.
- R2: A candidate competes only if its priority, taken from `prio_i[3*i +: 3]`, is strictly greater than `thresh_i`. A priority equal to the threshold never produces a request.
- R3: Among the competing sources the one with the greatest priority is reported. When priorities are equal, the lowest source number is reported.
- R4: When no source competes, `win_id_o` is 0 and `win_prio_o` is 0. Source 0 is never reported, whatever its inputs are.
- R5: `irq_o` is 1 exactly when some source competes, which is the same as `win_id_o` being nonzero.
- R6: A source with priority 0 is never reported.
- R7: With `REG_OUT`=1 (the default), the results reflect the inputs present at the previous rising clock edge. While `rst` is high at a clock edge, all outputs are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (used by the output stage) |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| pend_i | input | NUM_SRC | Pending bit per source |
| en_i | input | NUM_SRC | Enable bit per source for this target |
| clm_i | input | NUM_SRC | Claimed (in service) bit per source |
| prio_i | input | 3*NUM_SRC | Priority per source, source i in bits [3i+2:3i] |
| thresh_i | input | 3 | Target threshold |
| irq_o | output | 1 | Interrupt request level |
| win_id_o | output | $clog2(NUM_SRC) | Winning source number, 0 for none |
| win_prio_o | output | 3 | Priority of the winner, 0 for none |

## Verification
Random vectors with random thresholds exercise the general selection against a linear-scan model. Vectors where every pending source sits exactly at the threshold separate a strict comparison from an inclusive one. Vectors where all sources share one priority above the threshold expose the tie rule, because a tree that favours the wrong child reports a higher number. Dedicated patterns cover the other cases: all-zero inputs, only source 0 active, claimed or disabled sources at top priority, priority 0 with a zero threshold, and activity during reset. Each of these singles out one masking term or boundary.

// File: rtl/prio_arb_pkg.sv
package prio_arb_pkg;

    localparam int PRIO_W = 3;

    typedef logic [PRIO_W-1:0] prio_t;

    // True when priority a is strictly better than priority b.
    function automatic logic prio_beats(prio_t a, prio_t b);
        return a > b;
    endfunction

    // Width of a packed candidate: valid flag, priority, source number.
    function automatic int cand_width(int id_w);
        return 1 + PRIO_W + id_w;
    endfunction

endpackage

// File: rtl/arb_cand_mask.sv
module arb_cand_mask
    import prio_arb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ID_W    = $clog2(NUM_SRC),
    parameter int LEAVES  = 1 << ID_W,
    localparam int CW     = 1 + PRIO_W + ID_W
) (
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        clm_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  prio_t                     thresh_i,
    output logic [LEAVES*CW-1:0]      leaf_o
);
    typedef struct packed {
        logic            vld;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } cand_t;

    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        cand_t c;
        if (i == 0 || i >= NUM_SRC) begin : g_off
            // Source 0 is reserved; padding leaves never compete.
            assign c = '0;
        end else begin : g_on
            prio_t p;
            assign p      = prio_i[i*PRIO_W +: PRIO_W];
            assign c.vld  = pend_i[i] & en_i[i] & ~clm_i[i] & prio_beats(p, thresh_i);
            assign c.prio = p;
            assign c.id   = ID_W'(i);
        end
        assign leaf_o[i*CW +: CW] = c;
    end

    if (NUM_SRC > 0) begin : g_src0_unused
        logic unused_src0;
        assign unused_src0 = ^{pend_i[0], en_i[0], clm_i[0], prio_i[PRIO_W-1:0]};
    end
endmodule

// File: rtl/arb_sel_node.sv
module arb_sel_node
    import prio_arb_pkg::*;
#(
    parameter int ID_W = 5,
    localparam int CW  = 1 + PRIO_W + ID_W
) (
    input  logic [CW-1:0] lo_i,
    input  logic [CW-1:0] hi_i,
    output logic [CW-1:0] win_o
);
    typedef struct packed {
        logic            vld;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } cand_t;

    cand_t lo, hi;
    logic  take_hi;

    assign lo = lo_i;
    assign hi = hi_i;

    // The lower-numbered side keeps the slot unless the upper side is strictly better.
    always_comb begin
        take_hi = hi.vld && (!lo.vld || prio_beats(hi.prio, lo.prio));
        win_o   = take_hi ? hi_i : lo_i;
    end
endmodule

// File: rtl/arb_sel_tree.sv
module arb_sel_tree
    import prio_arb_pkg::*;
#(
    parameter int ID_W   = 5,
    parameter int LEAVES = 1 << ID_W,
    localparam int CW    = 1 + PRIO_W + ID_W,
    localparam int NODES = 2 * LEAVES - 1
) (
    input  logic [LEAVES*CW-1:0] leaf_i,
    output logic [CW-1:0]        best_o
);
    logic [CW-1:0] nd [NODES];

    // Heap layout: node k has children 2k+1 (lower numbers) and 2k+2.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        assign nd[LEAVES-1+i] = leaf_i[i*CW +: CW];
    end

    for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
        arb_sel_node #(.ID_W(ID_W)) u_node (
            .lo_i (nd[2*k+1]),
            .hi_i (nd[2*k+2]),
            .win_o(nd[k])
        );
    end

    assign best_o = nd[0];
endmodule

// File: rtl/arb_out_stage.sv
module arb_out_stage
    import prio_arb_pkg::*;
#(
    parameter int ID_W    = 5,
    parameter bit REG_OUT = 1'b1,
    localparam int CW     = 1 + PRIO_W + ID_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CW-1:0]   best_i,
    output logic            irq_o,
    output logic [ID_W-1:0] id_o,
    output prio_t           prio_o
);
    typedef struct packed {
        logic            vld;
        prio_t           prio;
        logic [ID_W-1:0] id;
    } cand_t;

    cand_t best, shown;

    assign best = best_i;

    // Invalid results are forced to zero so that ID 0 always means "none".
    always_comb begin
        shown      = '0;
        shown.vld  = best.vld;
        shown.prio = best.vld ? best.prio : '0;
        shown.id   = best.vld ? best.id   : '0;
    end

    if (REG_OUT) begin : g_reg
        cand_t q;
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= shown;
        end
        assign irq_o  = q.vld;
        assign id_o   = q.id;
        assign prio_o = q.prio;
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst;
        assign irq_o  = shown.vld;
        assign id_o   = shown.id;
        assign prio_o = shown.prio;
    end
endmodule

// File: rtl/prio_thresh_arb.sv
module prio_thresh_arb
    import prio_arb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int ID_W   = (NUM_SRC > 2) ? $clog2(NUM_SRC) : 1,
    localparam int LEAVES = 1 << ID_W,
    localparam int CW     = 1 + PRIO_W + ID_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        pend_i,
    input  logic [NUM_SRC-1:0]        en_i,
    input  logic [NUM_SRC-1:0]        clm_i,
    input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]         thresh_i,
    output logic                      irq_o,
    output logic [ID_W-1:0]           win_id_o,
    output logic [PRIO_W-1:0]         win_prio_o
);
    logic [LEAVES*CW-1:0] leaves;
    logic [CW-1:0]        best;

    arb_cand_mask #(.NUM_SRC(NUM_SRC), .ID_W(ID_W), .LEAVES(LEAVES)) u_mask (
        .pend_i  (pend_i),
        .en_i    (en_i),
        .clm_i   (clm_i),
        .prio_i  (prio_i),
        .thresh_i(thresh_i),
        .leaf_o  (leaves)
    );

    arb_sel_tree #(.ID_W(ID_W), .LEAVES(LEAVES)) u_tree (
        .leaf_i(leaves),
        .best_o(best)
    );

    arb_out_stage #(.ID_W(ID_W), .REG_OUT(REG_OUT)) u_out (
        .clk   (clk),
        .rst   (rst),
        .best_i(best),
        .irq_o (irq_o),
        .id_o  (win_id_o),
        .prio_o(win_prio_o)
    );
endmodule

// File: rtl/prio_thresh_arb_chk.sv
module prio_thresh_arb_chk
    import prio_arb_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter bit REG_OUT = 1'b1,
    localparam int ID_W   = (NUM_SRC > 2) ? $clog2(NUM_SRC) : 1
) (
    input logic                      clk,
    input logic                      rst,
    input logic [NUM_SRC-1:0]        pend_i,
    input logic [NUM_SRC-1:0]        en_i,
    input logic [NUM_SRC-1:0]        clm_i,
    input logic [NUM_SRC*PRIO_W-1:0] prio_i,
    input logic [PRIO_W-1:0]         thresh_i,
    input logic                      irq_o,
    input logic [ID_W-1:0]           win_id_o,
    input logic [PRIO_W-1:0]         win_prio_o
);
    // Inputs aligned with the outputs they produced.
    logic [NUM_SRC-1:0]        pend_a, en_a, clm_a;
    logic [NUM_SRC*PRIO_W-1:0] prio_a;
    logic [PRIO_W-1:0]         th_a;
    logic                      aligned;

    if (REG_OUT) begin : g_dly
        always_ff @(posedge clk) begin
            pend_a  <= pend_i;
            en_a    <= en_i;
            clm_a   <= clm_i;
            prio_a  <= prio_i;
            th_a    <= thresh_i;
            aligned <= !rst;
        end

        // R7: a reset edge leaves every output at zero
        p_reset_clear_r7: assert property (@(posedge clk)
            $past(rst) |-> (!irq_o && win_id_o == '0 && win_prio_o == '0));
    end else begin : g_now
        assign pend_a  = pend_i;
        assign en_a    = en_i;
        assign clm_a   = clm_i;
        assign prio_a  = prio_i;
        assign th_a    = thresh_i;
        assign aligned = 1'b1;
    end

    p_irq_id_r5: assert property (@(posedge clk) disable iff (rst)
        irq_o == (win_id_o != '0));

    p_cand_mask_r1: assert property (@(posedge clk) disable iff (rst)
        (aligned && irq_o) |-> (pend_a[win_id_o] && en_a[win_id_o] && !clm_a[win_id_o]));

    p_above_thresh_r2: assert property (@(posedge clk) disable iff (rst)
        (aligned && irq_o) |-> (win_prio_o > th_a));

    p_prio_match_r3: assert property (@(posedge clk) disable iff (rst)
        (aligned && irq_o) |-> (win_prio_o == prio_a[win_id_o*PRIO_W +: PRIO_W]));

    p_none_zero_r4: assert property (@(posedge clk) disable iff (rst)
        !irq_o |-> (win_id_o == '0 && win_prio_o == '0));

    p_prio0_never_r6: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> (win_prio_o != '0));
endmodule

bind prio_thresh_arb prio_thresh_arb_chk #(.NUM_SRC(NUM_SRC), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_prio_thresh_arb.sv
module sim_prio_thresh_arb;
    localparam int N  = 32;
    localparam int PW = 3;
    localparam int IW = $clog2(N);

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [N-1:0]    pend = '0, en = '0, clm = '0;
    logic [N*PW-1:0] prio = '0;
    logic [PW-1:0]   th = '0;
    logic            irq;
    logic [IW-1:0]   wid;
    logic [PW-1:0]   wprio;

    int n_cmp = 0;
    int n_bad = 0;
    int e_irq = 0, e_id = 0, e_pr = 0;

    always #2 clk = ~clk;  // 250 MHz

    prio_thresh_arb #(.NUM_SRC(N), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .pend_i(pend), .en_i(en), .clm_i(clm),
        .prio_i(prio), .thresh_i(th), .irq_o(irq), .win_id_o(wid), .win_prio_o(wprio)
    );

    // Linear scan reference, written from the requirements.
    task automatic model();
        int best = th;
        int id = 0;
        for (int i = 1; i < N; i++) begin
            int p = int'(prio[i*PW +: PW]);
            if (pend[i] && en[i] && !clm[i] && p > best) begin
                best = p;
                id = i;
            end
        end
        e_id  = id;
        e_irq = (id != 0) ? 1 : 0;
        e_pr  = (id != 0) ? best : 0;
    endtask

    task automatic chk(string tag, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk(tag, "irq", int'(irq), e_irq);
        chk(tag, "id", int'(wid), e_id);
        chk(tag, "prio", int'(wprio), e_pr);
    endtask

    // Called at a negedge with new inputs already set: checks hold, then result.
    task automatic apply(string tag);
        int old_irq = e_irq, old_id = e_id;
        model();
        #1;
        chk("R7", "hold irq", int'(irq), old_irq);
        chk("R7", "hold id", int'(wid), old_id);
        @(negedge clk);
        check_all(tag);
    endtask

    task automatic set_all_prio(int p);
        for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'(p);
    endtask

    initial begin
        // R7: reset clears outputs even with live inputs
        pend = '1; en = '1; set_all_prio(7);
        repeat (3) @(negedge clk);
        e_irq = 0; e_id = 0; e_pr = 0;
        check_all("R7");
        rst = 1'b0;
        pend = '0; en = '0; set_all_prio(0);
        apply("R4");                       // all zero: nothing

        // R2: every priority equals the threshold
        pend = '1; en = '1; clm = '0; th = 3; set_all_prio(3);
        apply("R2");
        th = 2;
        apply("R2");                       // one above: source 1 wins
        // R3: all tied above threshold, lowest number wins
        th = 0; set_all_prio(5); pend = '0; pend[9] = 1; pend[20] = 1; pend[31] = 1;
        apply("R3");
        prio[20*PW +: PW] = 6;
        apply("R3");
        // R1: claimed and disabled sources at top priority are skipped
        pend = '1; set_all_prio(1); prio[4*PW +: PW] = 7; prio[7*PW +: PW] = 7; prio[12*PW +: PW] = 6;
        clm[4] = 1; en[7] = 0;
        apply("R1");
        // R4: only source 0 active
        clm = '0; en = '1; pend = '0; pend[0] = 1; set_all_prio(0); prio[PW-1:0] = 7;
        apply("R4");
        // R6: priority 0 with threshold 0
        pend = '1; set_all_prio(0); th = 0;
        apply("R6");
        // R5: threshold at maximum blocks everything
        set_all_prio(7); th = 7;
        apply("R5");
        th = 6; pend = '0; pend[N-1] = 1;
        apply("R5");

        // R3: random patterns with random thresholds
        for (int k = 0; k < 3000; k++) begin
            pend = N'($urandom()); en = N'($urandom()); clm = N'($urandom()) & N'($urandom());
            for (int i = 0; i < N; i++) prio[i*PW +: PW] = PW'($urandom_range(0, 7));
            th = PW'($urandom_range(0, (k % 4 == 0) ? 7 : 3));
            apply("R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule